// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block brings an SRAM-based programmable device from power-down to a configured state over a passive serial link. A single-cycle start command switches the target's power on, drives the active-low configuration request low for a fixed time measured in system clocks, and then releases it. Configuration bytes then arrive on a valid/ready stream. Each byte is serialised onto the data pin least-significant bit first, with one bit per rising edge of the configuration clock.

When the byte marked last has been sent, the loader runs a fixed burst of further clock strobes with the data pin held at zero. It then samples the two device status inputs through a two-flop synchronizer. Success is reported only when the device shows both "no error" and "loaded". Any other combination raises the error flag and reports the captured 2-bit status. The result stays on the outputs until the next start command.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, dev_pwr_down=1, cfg_req_n=1, dclk=0, data0=0, in_ready=0, busy=0, done=0 and err=0.
- R2: A start pulse while idle drives dev_pwr_down low in the cycle where cfg_req_n first goes low, and dev_pwr_down stays low from then on.
- R3: cfg_req_n is low for exactly RESET_CYC = CLK_HZ/1e6 * RESET_US system cycles (10000 at the defaults), once per load, and dclk shows no rising edge while it is low.
- R4: A byte is taken on a cycle with in_valid and in_ready both high, and it goes out on data0 bit 0 first. Each bit is presented on one dclk rising edge, eight edges per byte, and data0 does not change while dclk is high.
- R5: Within a byte and within the trailing burst, dclk rising edges are exactly 2*DIV_HALF system cycles apart, and every dclk high phase lasts DIV_HALF cycles.
- R6: After the byte flagged in_last, exactly TRAIL_CLKS further dclk rising edges occur (50 by default), with data0 at 0 on each. No further byte is accepted during this burst, even when in_valid is high.
- R7: When both synchronized status inputs are high after the trailing burst, the result is done=1, err=0 and res_status=2'b11.
- R8: Any other status combination gives err=1 and done=0, with res_status[1]=dev_loaded and res_status[0]=dev_ok.
- R9: A start pulse while busy=1 is ignored: cfg_req_n is not pulsed again and the byte stream carries on unchanged.
- R10: done, err and res_status hold their values until the next start. That start clears done and err in the following cycle and raises busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle load command |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream configuration byte |
| in_last | input | 1 | Marks the final byte of the bitstream |
| in_ready | output | 1 | Loader can accept a byte |
| busy | output | 1 | Load sequence in progress |
| done | output | 1 | Last load succeeded (held) |
| err | output | 1 | Last load failed (held) |
| res_status | output | 2 | Captured status: bit 1 loaded, bit 0 ok |
| dev_pwr_down | output | 1 | Target power-down control, 1 = powered off |
| cfg_req_n | output | 1 | Active-low configuration request to target |
| dclk | output | 1 | Configuration bit clock |
| data0 | output | 1 | Configuration serial data |
| dev_ok | input | 1 | Target status, low = error (asynchronous) |
| dev_loaded | input | 1 | Target configuration-complete flag (asynchronous) |

## Verification
A start command can land in the same cycle as a byte handshake, and that is where the ignore rule and the stream path compete. The bench raises start in the cycle where a mid-stream byte is accepted. It then judges the run by counting cfg_req_n low pulses, which must stay at one. It also compares the full dclk-sampled bit log against the LSB-first expansion of the sent bytes followed by fifty zeros. A second overlap is start arriving while the previous result is still held. There the bench checks that the flags clear one cycle later and that a fresh reset pulse of the full length follows.

// File: rtl/ps_cfg_pkg.sv
// Shared types for the passive serial configuration loader.
// Assumes: one loader instance per target device.
package ps_cfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT,
        ST_SHIFT,
        ST_TRAIL,
        ST_CHECK
    } ld_state_t;

    localparam int STAT_W      = 2;
    localparam int STAT_OK_BIT = 0;
    localparam int STAT_LD_BIT = 1;
endpackage

// File: rtl/ps_strobe_gen.sv
// Bit-clock phase generator: while run is high, produces a clock that is
// low for DIV_HALF cycles and then high for DIV_HALF cycles. wrap marks the
// last cycle of each period. Assumes: run low returns the phase to zero.
module ps_strobe_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic clk_hi,
    output logic wrap
);
    localparam int PERIOD = 2 * DIV_HALF;
    localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(DIV_HALF);

    logic [PH_W-1:0] ph;

    // Phase counter: counts through one bit period while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   ph <= '0;
        else if (ph == PH_LAST) ph <= '0;
        else                    ph <= ph + 1'b1;
    end

    assign clk_hi = run && (ph >= PH_HIGH);
    assign wrap   = run && (ph == PH_LAST);
endmodule

// File: rtl/ps_status_sync.sv
// Two-flop synchronizer for asynchronous status inputs.
// Assumes: each bit is quasi-static, so no cross-bit coherence is needed.
module ps_status_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= '0;
            q_sync <= '0;
        end else begin
            meta   <= d_async;
            q_sync <= meta;
        end
    end
endmodule

// File: rtl/ps_cfg_loader.sv
// Passive serial configuration loader. It powers the target, times the
// configuration request pulse, serialises stream bytes LSB first on the bit
// clock, issues a trailing clock burst and then judges the two status inputs.
// Assumes: clk runs at CLK_HZ, and CLK_HZ is a multiple of 1 MHz.
module ps_cfg_loader
    import ps_cfg_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int RESET_US   = 200,
    parameter int DIV_HALF   = 2,
    parameter int TRAIL_CLKS = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [STAT_W-1:0] res_status,
    output logic              dev_pwr_down,
    output logic              cfg_req_n,
    output logic              dclk,
    output logic              data0,
    input  logic              dev_ok,
    input  logic              dev_loaded
);
    localparam int RESET_CYC = (CLK_HZ / 1_000_000) * RESET_US;
    localparam int PC_W      = $clog2(RESET_CYC + 1);
    localparam int TC_W      = $clog2(TRAIL_CLKS + 1);
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(RESET_CYC - 1);
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(TRAIL_CLKS - 1);

    ld_state_t         state;
    logic [PC_W-1:0]   pulse_cnt;
    logic [TC_W-1:0]   trail_cnt;
    logic [7:0]        shreg;
    logic [2:0]        bit_cnt;
    logic              last_q;
    logic              pwr_down_q;
    logic              done_q;
    logic              err_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] stat_sync;
    logic              run;
    logic              clk_hi;
    logic              wrap;

    assign run = (state == ST_SHIFT) || (state == ST_TRAIL);

    ps_strobe_gen #(.DIV_HALF(DIV_HALF)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clk_hi (clk_hi),
        .wrap   (wrap)
    );

    logic [STAT_W-1:0] stat_raw;
    always_comb begin
        stat_raw              = '0;
        stat_raw[STAT_OK_BIT] = dev_ok;
        stat_raw[STAT_LD_BIT] = dev_loaded;
    end

    ps_status_sync #(.W(STAT_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (stat_raw),
        .q_sync  (stat_sync)
    );

    // Sequencer: power, request pulse, byte intake, shifting, trailing burst, check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pulse_cnt  <= '0;
            trail_cnt  <= '0;
            shreg      <= '0;
            bit_cnt    <= '0;
            last_q     <= 1'b0;
            pwr_down_q <= 1'b1;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            stat_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state      <= ST_PULSE;
                    pulse_cnt  <= '0;
                    pwr_down_q <= 1'b0;
                    done_q     <= 1'b0;
                    err_q      <= 1'b0;
                end
                ST_PULSE: begin
                    if (pulse_cnt == PC_LAST) state <= ST_WAIT;
                    else                      pulse_cnt <= pulse_cnt + 1'b1;
                end
                ST_WAIT: if (in_valid) begin
                    shreg   <= in_data;
                    last_q  <= in_last;
                    bit_cnt <= '0;
                    state   <= ST_SHIFT;
                end
                ST_SHIFT: if (wrap) begin
                    shreg   <= {1'b0, shreg[7:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == 3'd7) begin
                        trail_cnt <= '0;
                        state     <= last_q ? ST_TRAIL : ST_WAIT;
                    end
                end
                ST_TRAIL: if (wrap) begin
                    if (trail_cnt == TC_LAST) state <= ST_CHECK;
                    else                      trail_cnt <= trail_cnt + 1'b1;
                end
                ST_CHECK: begin
                    stat_q <= stat_sync;
                    done_q <= &stat_sync;
                    err_q  <= ~&stat_sync;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_ready     = (state == ST_WAIT);
    assign busy         = (state != ST_IDLE);
    assign done         = done_q;
    assign err          = err_q;
    assign res_status   = stat_q;
    assign dev_pwr_down = pwr_down_q;
    assign cfg_req_n    = (state != ST_PULSE);
    assign dclk         = clk_hi;
    assign data0        = (state == ST_SHIFT) ? shreg[0] : 1'b0;
endmodule

// File: rtl/ps_cfg_loader_chk.sv
// Property checker for ps_cfg_loader, attached through bind.
// Assumes: observes the top-level ports only.
module ps_cfg_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [1:0] res_status,
    input logic       dev_pwr_down,
    input logic       cfg_req_n,
    input logic       dclk,
    input logic       data0
);
    // R3: no bit strobe while the configuration request is held low
    assert_no_clk_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req_n |-> !dclk);

    // R2: target is powered whenever the request is low
    assert_power_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req_n |-> !dev_pwr_down);

    // R2: once powered, power stays on
    assert_power_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_pwr_down |=> !dev_pwr_down);

    // R4: data held steady across the dclk high phase
    assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk && $past(dclk)) |-> $stable(data0));

    // R7: success flag only with full status
    assert_done_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_status == 2'b11 && !err));

    // R8: error flag never with full status
    assert_err_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (res_status != 2'b11 && !done));

    // R9: request pulse is not repeated inside one busy interval
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_req_n) |=> cfg_req_n);

    // R10: result flags are not visible while a load runs
    assert_result_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !err));

    // R4: bytes are only taken during a load
    assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> busy);
endmodule

bind ps_cfg_loader ps_cfg_loader_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .res_status   (res_status),
    .dev_pwr_down (dev_pwr_down),
    .cfg_req_n    (cfg_req_n),
    .dclk         (dclk),
    .data0        (data0)
);

// File: tb/sim_ps_cfg_loader.sv
module sim_ps_cfg_loader;
    localparam int DIV_HALF   = 2;
    localparam int PERIOD     = 2 * DIV_HALF;
    localparam int TRAIL_CLKS = 50;
    localparam int RESET_CYC  = 10000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       dev_ok = 1'b0;
    logic       dev_loaded = 1'b0;
    logic       in_ready, busy, done, err, dev_pwr_down, cfg_req_n, dclk, data0;
    logic [1:0] res_status;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [7:0] tx [0:15];
    int rise_t [0:511];
    bit rise_d [0:511];
    int nrise, low_run, max_low, req_falls, clk_in_low, hi_run, hi_bad;
    logic prev_dclk, prev_req;

    always #10 clk = ~clk;

    ps_cfg_loader u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready), .busy(busy),
        .done(done), .err(err), .res_status(res_status),
        .dev_pwr_down(dev_pwr_down), .cfg_req_n(cfg_req_n), .dclk(dclk),
        .data0(data0), .dev_ok(dev_ok), .dev_loaded(dev_loaded)
    );

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (dclk && !prev_dclk && nrise < 512) begin
                rise_t[nrise] = cyc;
                rise_d[nrise] = data0;
                nrise = nrise + 1;
            end
            if (dclk) hi_run = hi_run + 1;
            else if (prev_dclk) begin
                if (hi_run != DIV_HALF) hi_bad = hi_bad + 1;
                hi_run = 0;
            end
            if (!cfg_req_n) begin
                low_run = low_run + 1;
                if (dclk) clk_in_low = clk_in_low + 1;
                if (low_run > max_low) max_low = low_run;
            end else low_run = 0;
            if (!cfg_req_n && prev_req) req_falls = req_falls + 1;
        end
        prev_dclk = dclk;
        prev_req  = cfg_req_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        nrise = 0; low_run = 0; max_low = 0; req_falls = 0;
        clk_in_low = 0; hi_run = 0; hi_bad = 0;
    endtask

    // Runs a full load of n bytes from tx; gap adds idle cycles before each
    // byte; clash_at raises start together with that byte's handshake.
    task automatic run_load(input int n, input int gap, input int clash_at,
                            input bit ok, input bit ld);
        int to;
        dev_ok = ok; dev_loaded = ld;
        clear_log();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1 && done == 1'b0 && err == 1'b0, "R10", {busy, done, err}, 3'b100);
        check(dev_pwr_down == 1'b0 && cfg_req_n == 1'b0, "R2",
              {dev_pwr_down, cfg_req_n}, 0);
        for (int b = 0; b < n; b++) begin
            for (int g = 0; g < gap; g++) @(negedge clk);
            in_valid = 1'b1; in_data = tx[b]; in_last = (b == n - 1);
            to = 0;
            while (!in_ready && to < 20000) begin @(negedge clk); to++; end
            if (b == clash_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (b != n - 1) in_valid = 1'b0;
        end
        // Junk offered during the trailing burst must not be taken (R6).
        in_data = 8'hFF; in_last = 1'b0;
        to = 0;
        while (busy && to < 2000) begin @(negedge clk); to++; end
        in_valid = 1'b0;
        check(nrise == 8 * n + TRAIL_CLKS, "R6", nrise, 8 * n + TRAIL_CLKS);
        begin
            int bitbad = 0;
            for (int k = 0; k < 8 * n && k < nrise; k++)
                if (rise_d[k] != tx[k / 8][k % 8]) bitbad++;
            check(bitbad == 0, "R4", bitbad, 0);
        end
        begin
            int zbad = 0;
            for (int k = 8 * n; k < nrise; k++) if (rise_d[k] != 1'b0) zbad++;
            check(zbad == 0, "R6", zbad, 0);
        end
        begin
            int pbad = 0;
            for (int k = 0; k + 1 < nrise; k++)
                if (((k % 8) != 7 || k >= 8 * n - 1) && rise_t[k + 1] - rise_t[k] != PERIOD)
                    pbad++;
            check(pbad == 0 && hi_bad == 0, "R5", pbad + hi_bad, 0);
        end
        check(max_low == RESET_CYC && clk_in_low == 0, "R3", max_low, RESET_CYC);
        check(req_falls == 1, "R9", req_falls, 1);
        check(dev_pwr_down == 1'b0, "R2", dev_pwr_down, 0);
    endtask

    task automatic test_reset();
        check(dev_pwr_down && cfg_req_n && !dclk && !data0 && !in_ready &&
              !busy && !done && !err, "R1",
              {dev_pwr_down, cfg_req_n, dclk, data0, in_ready, busy, done, err},
              8'b11000000);
    endtask

    task automatic test_success();
        tx[0] = 8'hA5; tx[1] = 8'h01; tx[2] = 8'h80; tx[3] = 8'h3C;
        run_load(4, 0, -1, 1'b1, 1'b1);
        check(done && !err && res_status == 2'b11, "R7", {done, err, res_status}, 4'b1011);
    endtask

    task automatic test_err_loaded_only();
        tx[0] = 8'h96; tx[1] = 8'h7E;
        run_load(2, 3, -1, 1'b0, 1'b1);
        check(err && !done && res_status == 2'b10, "R8", {done, err, res_status}, 4'b0110);
    endtask

    task automatic test_err_ok_only_hold();
        tx[0] = 8'hF0;
        run_load(1, 0, -1, 1'b1, 1'b0);
        check(err && !done && res_status == 2'b01, "R8", {done, err, res_status}, 4'b0101);
        dev_ok = 1'b1; dev_loaded = 1'b1;
        repeat (20) @(negedge clk);
        check(err && !done && res_status == 2'b01, "R10", {done, err, res_status}, 4'b0101);
    endtask

    task automatic test_start_clash();
        tx[0] = 8'h5A; tx[1] = 8'hC3; tx[2] = 8'h0F;
        run_load(3, 1, 1, 1'b1, 1'b1);
        check(done && !err && res_status == 2'b11, "R9", {done, err, res_status}, 4'b1011);
    endtask

    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_log();
        prev_dclk = 1'b0; prev_req = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_success();
        test_err_loaded_only();
        test_err_ok_only_hold();
        test_start_clash();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule